// File: doc/BRIEF.md
# Clock and Power Status Controller

This block holds the status and control word of a processor's clock and power-management unit. It keeps three sticky status flags, each cleared by writing a 1 to it. The first records a PLL loss of lock that software did not cause. The second is a timer-expired flag, and it drives an external pin. The third records any timer interrupt. The word also holds a timer-expired enable, a clock-source bit that selects the high or low clock divider, and a three-bit low-power-mode field.

Software writes the whole word through a single write strobe, and the current register contents are always visible on the read-back bus. Hardware inputs feed the flags and the mode field: PLL lock, four timer-event pulses, a software relock qualifier and a low-power exit pulse. The PLL, the dividers and the timers themselves are outside this block. None of the ports carry a data stream, so every pin is a plain level or pulse and there is no back-pressure.

Top module: `clkpwr_stat_ctrl`

## Requirements
- R1: The lock-lost flag (bit 0) sets one edge after `pll_locked` is sampled falling from 1 to 0. It stays set until a write with bit 0 = 1, and a write with bit 0 = 0 leaves it unchanged.
- R2: The lock-lost flag does not set on a lock fall while `sw_relock` is high, or while the mode field holds deep sleep (011) or power-down (100). In every other mode it does set.
- R3: The timer-expired flag (bit 1) resets to 1. It sets on the edge after any `tmr_evt` bit is high, but only if the timer enable (bit 3) is 1. A write with bit 1 = 1 clears it.
- R4: `texp_o` equals the timer-expired flag at all times.
- R5: The timer-interrupt flag (bit 2) resets to 0. It sets on the edge after any `tmr_evt` bit is high, whatever the enable bit holds. A write with bit 2 = 1 clears it.
- R6: When a hardware set and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: `div_sel_low` is 1 only while the clock-source bit (bit 4) is 1 and the timer-interrupt flag is 0. It comes from a flop and changes on the same edge as the register bits it depends on.
- R8: The mode field (bits 7:5) resets to 000 (normal). Writes of 000 (normal), 001 (doze), 010 (sleep), 011 (deep sleep) or 100 (power-down) are taken. Writes of 101 to 111 leave the field unchanged, while the other bits of the same write still take effect.
- R9: An `lp_exit` pulse returns the mode field to 000 on the next edge, and it overrides a mode write in the same cycle.
- R10: `rd_data` shows {mode[2:0], clock source, timer enable, timer-interrupt, timer-expired, lock-lost} from bit 7 down to bit 0. Its reset value is 8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 8 | Write data; the flag bits are write-1-to-clear |
| rd_data | output | 8 | Current register contents |
| pll_locked | input | 1 | PLL lock indication |
| sw_relock | input | 1 | High while software is changing the PLL multiplier or enable |
| tmr_evt | input | 4 | Timer event pulses: periodic, RTC alarm, timebase alarm, decrementer |
| lp_exit | input | 1 | Low-power exit pulse |
| div_sel_low | output | 1 | 1 selects the low divider, 0 the high divider |
| mode_o | output | 3 | Current low-power mode |
| texp_o | output | 1 | External timer-expired pin |

## Verification
Every result appears one clock edge after its cause. This holds for a write, a timer event, a lock fall, an exit pulse, and the divider select that follows them. The lock-fall detector registers the previous lock level, so the flag still sets on the first edge at which a low level is sampled. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and compares on the next falling edge. It sweeps every timer-event pattern with the enable on and off, every mode code, and every pairing of clock source and pending interrupt.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
  localparam int REG_W     = 8;
  localparam int N_FLAGS   = 3;
  localparam int BIT_LOST  = 0;
  localparam int BIT_TEXP  = 1;
  localparam int BIT_TINT  = 2;
  localparam int BIT_TEN   = 3;
  localparam int BIT_CSRC  = 4;
  localparam int MODE_LSB  = 5;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    LPM_NORMAL = 3'd0,
    LPM_DOZE   = 3'd1,
    LPM_SLEEP  = 3'd2,
    LPM_DEEP   = 3'd3,
    LPM_PDOWN  = 3'd4
  } lpm_e;

  function automatic logic lpm_code_legal(logic [MODE_W-1:0] code);
    return code <= LPM_PDOWN;
  endfunction

  function automatic logic lpm_sw_unlocks(logic [MODE_W-1:0] code);
    return (code == LPM_DEEP) || (code == LPM_PDOWN);
  endfunction
endpackage

// File: rtl/clkpwr_w1c_flag.sv
module clkpwr_w1c_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  // set has priority so a coincident event is never lost
  assign nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= nxt_o;
  end
endmodule

// File: rtl/clkpwr_lock_loss.sv
module clkpwr_lock_loss
  import clkpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_locked_i,
  input  logic              sw_relock_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              loss_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pll_locked_i;
  end

  logic sw_cause;
  assign sw_cause = sw_relock_i | lpm_sw_unlocks(mode_i);
  assign loss_o   = prev_q & ~pll_locked_i & ~sw_cause;
endmodule

// File: rtl/clkpwr_lpm_reg.sv
module clkpwr_lpm_reg
  import clkpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] code_i,
  input  logic              exit_i,
  output logic [MODE_W-1:0] mode_o
);
  lpm_e mode_q;
  lpm_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (exit_i)                              mode_d = LPM_NORMAL;
    else if (wr_i && lpm_code_legal(code_i)) mode_d = lpm_e'(code_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LPM_NORMAL;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/clkpwr_clk_sel.sv
module clkpwr_clk_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic csrc_wdata_i,
  input  logic tint_nxt_i,
  output logic csrc_o,
  output logic div_sel_low_o
);
  logic csrc_d;
  assign csrc_d = wr_i ? csrc_wdata_i : csrc_o;

  // select computed from next-state values and registered: one flop, no glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csrc_o        <= 1'b0;
      div_sel_low_o <= 1'b0;
    end else begin
      csrc_o        <= csrc_d;
      div_sel_low_o <= csrc_d & ~tint_nxt_i;
    end
  end
endmodule

// File: rtl/clkpwr_stat_ctrl.sv
module clkpwr_stat_ctrl
  import clkpwr_pkg::*;
#(
  parameter int N_TMR_EVT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic                 pll_locked,
  input  logic                 sw_relock,
  input  logic [N_TMR_EVT-1:0] tmr_evt,
  input  logic                 lp_exit,
  output logic                 div_sel_low,
  output logic [MODE_W-1:0]    mode_o,
  output logic                 texp_o
);
  localparam logic [N_FLAGS-1:0] FLAG_RST = 3'b010;

  logic               any_evt;
  logic               lock_loss;
  logic               tmr_en_q;
  logic               csrc_q;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_clr;
  logic [N_FLAGS-1:0] flag_nxt;
  logic [N_FLAGS-1:0] flag_q;

  assign any_evt = |tmr_evt;

  clkpwr_lock_loss u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_locked_i (pll_locked),
    .sw_relock_i  (sw_relock),
    .mode_i       (mode_o),
    .loss_o       (lock_loss)
  );

  assign flag_set[BIT_LOST] = lock_loss;
  assign flag_set[BIT_TEXP] = any_evt & tmr_en_q;
  assign flag_set[BIT_TINT] = any_evt;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    assign flag_clr[i] = wr_en & wr_data[i];
    clkpwr_w1c_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[i]),
      .clr_i (flag_clr[i]),
      .nxt_o (flag_nxt[i]),
      .q_o   (flag_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmr_en_q <= 1'b0;
    else if (wr_en) tmr_en_q <= wr_data[BIT_TEN];
  end

  clkpwr_clk_sel u_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (wr_en),
    .csrc_wdata_i  (wr_data[BIT_CSRC]),
    .tint_nxt_i    (flag_nxt[BIT_TINT]),
    .csrc_o        (csrc_q),
    .div_sel_low_o (div_sel_low)
  );

  clkpwr_lpm_reg u_lpm (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_en),
    .code_i (wr_data[MODE_LSB +: MODE_W]),
    .exit_i (lp_exit),
    .mode_o (mode_o)
  );

  assign texp_o  = flag_q[BIT_TEXP];
  assign rd_data = {mode_o, csrc_q, tmr_en_q, flag_q};
endmodule

// File: rtl/clkpwr_stat_ctrl_chk.sv
module clkpwr_stat_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sw_relock,
  input logic [3:0] tmr_evt,
  input logic       lp_exit,
  input logic       div_sel_low,
  input logic [2:0] mode_o,
  input logic       texp_o
);
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !(wr_en && wr_data[0])) |=> rd_data[0]);

  a_r2_sw_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[0] && (sw_relock || mode_o == 3'd3 || mode_o == 3'd4)) |=> !rd_data[0]);

  a_r3_r4_pin_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && (|tmr_evt)) |=> texp_o);

  a_r5_tint_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_evt) |=> rd_data[2]);

  a_r7_high_forced: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2] |-> !div_sel_low);

  a_r7_follow_src: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[2] |-> (div_sel_low == rd_data[4]));

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:5] > 3'd4 && !lp_exit) |=> $stable(mode_o));

  a_r8_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd4);

  a_r9_exit: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit |=> (mode_o == 3'd0));
endmodule

bind clkpwr_stat_ctrl clkpwr_stat_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .sw_relock   (sw_relock),
  .tmr_evt     (tmr_evt),
  .lp_exit     (lp_exit),
  .div_sel_low (div_sel_low),
  .mode_o      (mode_o),
  .texp_o      (texp_o)
);

// File: tb/clkpwr_stat_ctrl_tb_top.sv
module clkpwr_stat_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       pll_locked;
  logic       sw_relock;
  logic [3:0] tmr_evt;
  logic       lp_exit;
  logic       div_sel_low;
  logic [2:0] mode_o;
  logic       texp_o;

  always #10 clk = ~clk;

  clkpwr_stat_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pll_locked(pll_locked), .sw_relock(sw_relock), .tmr_evt(tmr_evt),
    .lp_exit(lp_exit), .div_sel_low(div_sel_low), .mode_o(mode_o), .texp_o(texp_o)
  );

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   ended = 0;
  logic cur_en, cur_csrc;
  logic [2:0] cur_mode;

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] word(logic [2:0] clr);
    return {cur_mode, cur_csrc, cur_en, clr};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic lock_fall();
    pll_locked = 1'b1; tick(); tick();
    pll_locked = 1'b0; tick();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; pll_locked = 1'b0;
    sw_relock = 1'b0; tmr_evt = '0; lp_exit = 1'b0;
    cur_en = 1'b0; cur_csrc = 1'b0; cur_mode = 3'd0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10 / R3 / R4 / R5 / R8 reset state
    check("R10", "reset rd_data", rd_data, 8'h02);
    check("R4", "reset texp_o", texp_o, 1'b1);
    check("R7", "reset div_sel_low", div_sel_low, 1'b0);
    check("R8", "reset mode", mode_o, 3'd0);

    // R3 clear the reset-set timer-expired flag
    wr(word(3'b010));
    check("R3", "texp cleared", rd_data[1], 1'b0);
    check("R4", "pin cleared", texp_o, 1'b0);

    // R3 / R4 / R5 sweep every event pattern with enable off and on
    for (int en = 0; en < 2; en++) begin
      for (int ev = 0; ev < 16; ev++) begin
        cur_en = en[0];
        wr(word(3'b111));
        check("R5", "flags cleared before event", rd_data[2:1], 2'b00);
        tmr_evt = ev[3:0];
        tick();
        tmr_evt = '0;
        check("R3", "texp after event", rd_data[1], (en == 1 && ev != 0));
        check("R4", "texp_o after event", texp_o, (en == 1 && ev != 0));
        check("R5", "tint after event", rd_data[2], (ev != 0));
      end
    end

    // R6 set beats coincident clear
    cur_en = 1'b1;
    wr(word(3'b111));
    tmr_evt = 4'b0100; wr_en = 1'b1; wr_data = word(3'b110);
    tick();
    tmr_evt = '0; wr_en = 1'b0; wr_data = '0;
    check("R6", "timer flags survive clear", rd_data[2:1], 2'b11);
    // R3 R5 write of zero has no effect
    wr(word(3'b000));
    check("R5", "write 0 keeps flags", rd_data[2:1], 2'b11);
    wr(word(3'b111));

    // R1 lock loss
    lock_fall();
    check("R1", "lost set", rd_data[0], 1'b1);
    wr(word(3'b000));
    check("R1", "write 0 keeps lost", rd_data[0], 1'b1);
    wr(word(3'b001));
    check("R1", "w1c clears lost", rd_data[0], 1'b0);

    // R2 software-caused losses do not set
    pll_locked = 1'b1; tick(); tick();
    sw_relock = 1'b1; pll_locked = 1'b0; tick(); sw_relock = 1'b0;
    check("R2", "relock qualifier", rd_data[0], 1'b0);
    for (int m = 1; m < 5; m++) begin
      cur_mode = m[2:0];
      wr(word(3'b001));
      lock_fall();
      check("R2", "lost under mode", rd_data[0], (m != 3 && m != 4));
    end
    cur_mode = 3'd0;
    wr(word(3'b001));

    // R6 lost flag set beats clear
    pll_locked = 1'b1; tick(); tick();
    pll_locked = 1'b0; wr_en = 1'b1; wr_data = word(3'b001);
    tick();
    wr_en = 1'b0; wr_data = '0;
    check("R6", "lost survives clear", rd_data[0], 1'b1);
    wr(word(3'b111));

    // R7 divider select over clock source x pending interrupt
    for (int cs = 0; cs < 2; cs++) begin
      cur_csrc = cs[0];
      wr(word(3'b111));
      check("R7", "div follows source", div_sel_low, cs[0]);
      tmr_evt = 4'b1000; tick(); tmr_evt = '0;
      check("R7", "div forced high", div_sel_low, 1'b0);
      wr(word(3'b100));
      check("R7", "div after tint clear", div_sel_low, cs[0]);
    end
    cur_csrc = 1'b0;
    wr(word(3'b111));

    // R8 every mode code
    for (int c = 0; c < 8; c++) begin
      wr({c[2:0], cur_csrc, cur_en, 3'b000});
      if (c <= 4) cur_mode = c[2:0];
      check("R8", "mode after write", mode_o, cur_mode);
      check("R10", "mode read-back", rd_data[7:5], cur_mode);
    end
    // R8 reserved code still updates other fields
    wr({3'b110, 1'b1, 1'b0, 3'b000});
    check("R8", "reserved write other fields", rd_data[4:3], 2'b10);
    cur_csrc = 1'b1; cur_en = 1'b0;

    // R9 exit pulse
    lp_exit = 1'b1; tick(); lp_exit = 1'b0;
    cur_mode = 3'd0;
    check("R9", "exit alone", mode_o, 3'd0);
    cur_mode = 3'd2;
    wr(word(3'b000));
    check("R8", "sleep set", mode_o, 3'd2);
    lp_exit = 1'b1; wr_en = 1'b1; wr_data = {3'd1, cur_csrc, cur_en, 3'b000};
    tick();
    lp_exit = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R9", "exit beats write", mode_o, 3'd0);

    finish_run();
  end
endmodule